// File: doc/BRIEF.md
# Codec Hardware-Reset Sequencer

This block produces a timed reset waveform for an external audio codec that has an active-low reset pin. A single-cycle start strobe launches a three-phase sequence. First, the pin is held inactive (high) for a setup interval. Next, it is driven active (low) for a hold interval. Last, it is released high for a recovery interval. The block then emits a one-cycle completion pulse. System software or a downstream controller waits for that pulse before it programs the codec and before it takes its first reading of the jack-detect and output-routing state.

The phase durations are given in microseconds. A prescaler turns the clock into one tick per microsecond, using a cycles-per-microsecond parameter, and each phase counts those ticks. The default durations are 5000 us, 20000 us and 10000 us. When the board has no reset line fitted (the presence input is low), the block skips the waveform and reports completion on the next cycle. All pins are plain control and status; there is no data stream.

Top module: `codec_rst_seq`

## Requirements
- R1: After synchronous reset the reset pin is high, busy is low and done is low, and the pin stays high until a start strobe is accepted.
- R2: A start strobe sampled while idle with presence high makes busy high on the next cycle while the pin stays high for exactly SETUP_US*CYCLES_PER_US cycles.
- R3: The pin is then driven low for exactly HOLD_US*CYCLES_PER_US cycles.
- R4: The pin then returns high for exactly RELEASE_US*CYCLES_PER_US cycles, after which busy falls and done rises in the same cycle.
- R5: Done is a pulse of exactly one cycle and is never high while busy is high.
- R6: A start strobe sampled while idle with presence low produces done on the next cycle, and neither busy nor a low pin level appears.
- R7: A start strobe sampled while busy is ignored: the phase timing and the single done pulse of the running sequence are unchanged, and no second sequence follows.
- R8: The pin is low only while busy is high.
- R9: Presence is sampled only together with an accepted start; a change of presence during a sequence does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| present_i | input | 1 | High when a codec reset line is fitted |
| codec_rst_n_o | output | 1 | Codec reset pin, active low |
| busy_o | output | 1 | High while a sequence is running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: completion of one sequence and acceptance of the next start. The bench provokes this by placing a start strobe in the final busy cycle, where it must be ignored, and another in the cycle where done is high, where it must launch a fresh sequence. A scoreboard predicts the cycle of each pin edge and of each done pulse. It judges both cases from those stamps, and it reports any event that appears without a prediction.

// File: rtl/codec_rst_pkg.sv
package codec_rst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RELEASE = 2'd3
  } phase_e;
endpackage

// File: rtl/codec_rst_us_tick.sv
module codec_rst_us_tick #(
  parameter int CYCLES_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CW = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_US - 1);

  logic [CW-1:0] cnt_q;

  // one tick in the last cycle of every microsecond while running
  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i || !run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/codec_rst_phase_timer.sv
module codec_rst_phase_timer #(
  parameter int UW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [UW-1:0] len_i,
  output logic          last_o
);
  logic [UW-1:0] us_q;

  // last microsecond tick of the current phase
  assign last_o = tick_i && (us_q == (len_i - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      us_q <= '0;
    end else if (tick_i) begin
      us_q <= us_q + 1'b1;
    end
  end
endmodule

// File: rtl/codec_rst_seq_fsm.sv
module codec_rst_seq_fsm
  import codec_rst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   present_i,
  input  logic   last_i,
  output phase_e phase_o,
  output logic   load_o,
  output logic   pin_n_o,
  output logic   done_o
);
  phase_e phase_q;
  logic   pin_q;
  logic   done_q;
  logic   accept;

  assign accept  = (phase_q == PH_IDLE) && start_i && present_i;
  assign load_o  = accept || last_i;
  assign phase_o = phase_q;
  assign pin_n_o = pin_q;
  assign done_o  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pin_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            if (present_i) begin
              phase_q <= PH_SETUP;
              pin_q   <= 1'b1;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        PH_SETUP: begin
          if (last_i) begin
            phase_q <= PH_HOLD;
            pin_q   <= 1'b0;
          end
        end
        PH_HOLD: begin
          if (last_i) begin
            phase_q <= PH_RELEASE;
            pin_q   <= 1'b1;
          end
        end
        PH_RELEASE: begin
          if (last_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/codec_rst_seq.sv
module codec_rst_seq
  import codec_rst_pkg::*;
#(
  parameter int CYCLES_PER_US = 100,
  parameter int SETUP_US      = 5000,
  parameter int HOLD_US       = 20000,
  parameter int RELEASE_US    = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic present_i,
  output logic codec_rst_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_A = (SETUP_US > HOLD_US) ? SETUP_US : HOLD_US;
  localparam int MAX_US = (MAX_A > RELEASE_US) ? MAX_A : RELEASE_US;
  localparam int UW = $clog2(MAX_US + 1);

  phase_e        phase;
  logic          load;
  logic          tick;
  logic          last;
  logic [UW-1:0] len;

  assign busy_o = (phase != PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_HOLD:    len = UW'(HOLD_US);
      PH_RELEASE: len = UW'(RELEASE_US);
      default:    len = UW'(SETUP_US);
    endcase
  end

  codec_rst_us_tick #(.CYCLES_PER_US(CYCLES_PER_US)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (busy_o),
    .clear_i (load),
    .tick_o  (tick)
  );

  codec_rst_phase_timer #(.UW(UW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load),
    .tick_i  (tick),
    .len_i   (len),
    .last_o  (last)
  );

  codec_rst_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .present_i (present_i),
    .last_i    (last),
    .phase_o   (phase),
    .load_o    (load),
    .pin_n_o   (codec_rst_n_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/codec_rst_seq_chk.sv
module codec_rst_seq_chk #(
  parameter int CYCLES_PER_US = 100,
  parameter int SETUP_US      = 5000,
  parameter int HOLD_US       = 20000,
  parameter int RELEASE_US    = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic present_i,
  input logic codec_rst_n_o,
  input logic busy_o,
  input logic done_o
);
  localparam int HOLD_CYC  = HOLD_US * CYCLES_PER_US;
  localparam int REL_CYC   = RELEASE_US * CYCLES_PER_US;
  localparam int TOTAL_CYC = (SETUP_US + HOLD_US + RELEASE_US) * CYCLES_PER_US;

  int low_run;
  int high_run;
  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= 0;
      high_run <= 0;
      busy_run <= 0;
    end else begin
      low_run  <= !codec_rst_n_o ? low_run + 1 : 0;
      high_run <= codec_rst_n_o ? high_run + 1 : 0;
      busy_run <= busy_o ? busy_run + 1 : 0;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && present_i) |=> (busy_o && codec_rst_n_o));

  p_hold_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst_n_o) |-> (low_run == HOLD_CYC));

  p_release_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && high_run == REL_CYC));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_absent_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !present_i) |=> (done_o && !busy_o));

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_run == TOTAL_CYC));

  p_low_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n_o |-> busy_o);
endmodule

bind codec_rst_seq codec_rst_seq_chk #(
  .CYCLES_PER_US (CYCLES_PER_US),
  .SETUP_US      (SETUP_US),
  .HOLD_US       (HOLD_US),
  .RELEASE_US    (RELEASE_US)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .present_i     (present_i),
  .codec_rst_n_o (codec_rst_n_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/codec_rst_seq_tb.sv
module codec_rst_seq_tb;
  localparam int CPU = 3;
  localparam int SU  = 5;
  localparam int HU  = 20;
  localparam int RU  = 10;
  localparam int N   = SU * CPU;
  localparam int H   = HU * CPU;
  localparam int R   = RU * CPU;
  localparam int T   = N + H + R;

  typedef struct {
    int    kind;   // 0 pin fall, 1 pin rise, 2 done
    int    cyc;
    string req;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic present = 1'b0;
  logic pin;
  logic busy;
  logic done;

  int   cyc = 0;
  int   vectors = 0;
  int   fails = 0;
  logic prev_pin = 1'b1;
  ev_t  q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  codec_rst_seq #(
    .CYCLES_PER_US (CPU),
    .SETUP_US      (SU),
    .HOLD_US       (HU),
    .RELEASE_US    (RU)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .present_i     (present),
    .codec_rst_n_o (pin),
    .busy_o        (busy),
    .done_o        (done)
  );

  function automatic void check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  function automatic void observe(input int kind);
    ev_t e;
    if (q.size() == 0) begin
      check(1'b0, "R7 unexpected event", kind, -1);
      return;
    end
    e = q.pop_front();
    check(e.kind == kind, {e.req, " event kind"}, kind, e.kind);
    check(e.cyc == cyc, {e.req, " event cycle"}, cyc, e.cyc);
  endfunction

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_pin && !pin) observe(0);
      if (!prev_pin && pin) observe(1);
      if (done) observe(2);
    end
    prev_pin = pin;
  end

  // driver: called at a negedge; pulses start for one cycle
  task automatic issue(input bit pres, input bit accept);
    int c;
    ev_t e;
    c = cyc;
    if (accept) begin
      if (pres) begin
        e.kind = 0; e.cyc = c + 1 + N;     e.req = "R2"; q.push_back(e);
        e.kind = 1; e.cyc = c + 1 + N + H; e.req = "R3"; q.push_back(e);
        e.kind = 2; e.cyc = c + 1 + T;     e.req = "R4"; q.push_back(e);
      end else begin
        e.kind = 2; e.cyc = c + 1;         e.req = "R6"; q.push_back(e);
      end
    end
    present = pres;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pin == 1'b1, "R1 pin", pin, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);

    // basic sequence
    c = cyc;
    issue(1'b1, 1'b1);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(pin == 1'b1, "R2 pin high in setup", pin, 1);
    wait_to(c + 1 + N + 5);
    check(pin == 1'b0 && busy == 1'b1, "R8 low while busy", pin, 0);
    wait_to(c + 1 + T);
    check(busy == 1'b0, "R5 busy low with done", busy, 0);
    wait_to(c + T + 6);

    // absent codec
    issue(1'b0, 1'b1);
    check(busy == 1'b0, "R6 busy stays low", busy, 0);
    check(pin == 1'b1, "R6 pin stays high", pin, 1);
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && pin == 1'b1, "R6 no sequence", busy, 0);

    // starts while busy are ignored
    c = cyc;
    issue(1'b1, 1'b1);
    wait_to(c + 1 + N + 20);
    issue(1'b1, 1'b0);
    issue(1'b0, 1'b0);
    wait_to(c + 1 + N + H + 5);
    issue(1'b1, 1'b0);
    wait_to(c + T + 8);
    check(busy == 1'b0, "R7 no second sequence", busy, 0);

    // presence drops mid-sequence
    c = cyc;
    issue(1'b1, 1'b1);
    present = 1'b0;
    wait_to(c + 1 + N + 3);
    check(pin == 1'b0, "R9 hold continues", pin, 0);
    wait_to(c + T + 6);

    // completion and new start in the same cycle
    c = cyc;
    issue(1'b1, 1'b1);
    wait_to(c + T);
    issue(1'b1, 1'b0);          // sampled on the final busy edge: ignored
    check(done == 1'b1, "R5 done visible", done, 1);
    issue(1'b1, 1'b1);          // sampled while done is high: accepted
    check(busy == 1'b1, "R2 restart after done", busy, 1);
    wait_to(c + 2 * T + 8);

    check(q.size() == 0, "R4 all predicted events seen", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule